// File: doc/BRIEF.md
# NMI-Gated Transfer Activation Control

This block sits between a CPU register bus, a set of non-maskable event sources and a data transfer engine. It keeps one sticky flag that records that a non-maskable event has happened. While that flag is up, new requests to start a transfer are turned away. A transfer that is already running is allowed to finish. Four source inputs set the flag: watchdog expiry, oscillation stop, and two supply voltage monitors.

Software sees the flag as bit 0 of an 8-bit control register at address 0x80. The flag can only be cleared by a two-step handshake. Software must first read the register and see the flag as 1, and only then may it write 0 to the flag. This rule stops a write from wiping out an event that software never saw. The other seven bits are reserved.

The transfer side works as follows. A request is sampled, a one-cycle grant pulse is returned, and a busy indication is held until the engine reports completion.

Top module: `xfer_nmi_gate`

## Requirements
- R1: After synchronous reset, `nmi_flag`, `bus_rdata`, `act_grant` and `xfer_busy` are all 0.
- R2: A 1 on any bit of `nmi_src` in a cycle sets the flag at that clock edge. The bits are: bit 0 watchdog, bit 1 oscillation stop, bit 2 voltage monitor 1, bit 3 voltage monitor 2.
- R3: A read (`bus_rd`=1) at address 0x80 places the flag in bit 0 of `bus_rdata` in the following cycle. A read at any other address returns 0. `bus_rdata` holds its value between reads.
- R4: A write at 0x80 with data bit 0 equal to 0 clears the flag, provided the most recent read of 0x80 returned 1 and no write to 0x80 has happened since that read.
- R5: A write of 0 to the flag after a read of 0x80 that returned 0 leaves the flag unchanged. This also holds if the flag was set after that read.
- R6: A write with data bit 0 equal to 1 does not change the flag. A write to any address other than 0x80 changes neither the flag nor the armed read-1 condition.
- R7: Bits 7..1 of `bus_rdata` always read 0, and data written to bits 7..1 has no effect.
- R8: Every write to 0x80 disarms the clear. A later clear needs a fresh read of 0x80 that returns 1.
- R9: When a source event and a valid clearing write fall in the same cycle, the flag stays 1.
- R10: A request (`act_req`) made while the flag is 1 gets no grant and does not set busy. It is dropped, not held for later.
- R11: A request made while the flag is 0 and no transfer is busy gives a one-cycle `act_grant` pulse in the next cycle. `xfer_busy` rises in that same cycle and stays high through the cycle in which `xfer_done` is seen.
- R12: If the flag is set while a transfer is busy, busy still stays high until `xfer_done`.
- R13: Requests made while busy get no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 8 | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, one cycle after the read strobe |
| nmi_src | input | 4 | Event pulses: watchdog, oscillation stop, voltage monitor 1, voltage monitor 2 |
| nmi_flag | output | 1 | Current state of the sticky flag |
| act_req | input | 1 | Transfer activation request |
| xfer_done | input | 1 | Completion pulse from the transfer engine |
| act_grant | output | 1 | One-cycle grant to start a transfer |
| xfer_busy | output | 1 | A granted transfer is in progress |

## Verification
The hardest states to reach are those where the hidden armed condition disagrees with the visible flag. Examples are a flag that is set after a read returned 0, an armed clear that a write of 1 has already used up, and a source pulse that lands on the same edge as a valid clear. The directed part builds each of these on purpose, one after another. A constrained random phase then mixes reads, writes to 0x80 and a neighbouring address, sparse source pulses, requests and completions. A cycle model in the bench predicts every output on every cycle.

// File: rtl/xfer_gate_pkg.sv
package xfer_gate_pkg;

    // Bit position of the flag inside the control register
    localparam int unsigned FLAG_BIT = 0;

    // Decoded bus access for the current cycle
    typedef struct packed {
        logic rd_any;   // any read strobe
        logic rd_hit;   // read aimed at the control register
        logic wr_hit;   // write aimed at the control register
        logic clr_req;  // write to control register with flag bit 0
    } bus_op_t;

    typedef enum logic {
        GATE_IDLE = 1'b0,
        GATE_BUSY = 1'b1
    } gate_state_t;

endpackage

// File: rtl/xfer_bus_decode.sv
module xfer_bus_decode
    import xfer_gate_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'('h80)
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output bus_op_t           op
);
    localparam logic [DATA_W-1:0] FLAG_MASK = {{(DATA_W-1){1'b0}}, 1'b1} << FLAG_BIT;

    logic addr_hit;

    always_comb begin
        addr_hit   = (bus_addr == CTRL_ADDR);
        op.rd_any  = bus_rd;
        op.rd_hit  = bus_rd && addr_hit;
        op.wr_hit  = bus_wr && addr_hit;
        // Only the flag position matters; reserved bits are masked away
        op.clr_req = op.wr_hit && ((bus_wdata & FLAG_MASK) == '0);
    end
endmodule

// File: rtl/xfer_nmi_flag.sv
module xfer_nmi_flag
    import xfer_gate_pkg::*;
#(
    parameter int unsigned NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src,
    input  bus_op_t            op,
    output logic               flag
);
    logic [NUM_SRC:0] src_chain;
    logic             src_any;
    logic             flag_q;
    logic             armed_q;

    assign src_chain[0] = 1'b0;
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src_or
        assign src_chain[g+1] = src_chain[g] | src[g];
    end
    assign src_any = src_chain[NUM_SRC];

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            // A new event dominates a clear in the same cycle
            if (src_any) begin
                flag_q <= 1'b1;
            end else if (op.clr_req && armed_q) begin
                flag_q <= 1'b0;
            end
            // Every write disarms; a read arms with the value it returns
            if (op.wr_hit) begin
                armed_q <= 1'b0;
            end else if (op.rd_hit) begin
                armed_q <= flag_q;
            end
        end
    end

    assign flag = flag_q;
endmodule

// File: rtl/xfer_rd_port.sv
module xfer_rd_port
    import xfer_gate_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_op_t           op,
    input  logic              flag,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [DATA_W-1:0] FLAG_MASK = {{(DATA_W-1){1'b0}}, 1'b1} << FLAG_BIT;

    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (op.rd_any) begin
            rdata_q <= (op.rd_hit && flag) ? FLAG_MASK : '0;
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/xfer_act_gate.sv
module xfer_act_gate
    import xfer_gate_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic done,
    input  logic flag,
    output logic grant,
    output logic busy
);
    gate_state_t state_q, state_d;
    logic        grant_q, grant_d;

    always_comb begin
        state_d = state_q;
        grant_d = 1'b0;
        case (state_q)
            GATE_IDLE: begin
                if (req && !flag) begin
                    grant_d = 1'b1;
                    state_d = GATE_BUSY;
                end
            end
            GATE_BUSY: begin
                if (done) begin
                    state_d = GATE_IDLE;
                end
            end
            default: state_d = GATE_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GATE_IDLE;
            grant_q <= 1'b0;
        end else begin
            state_q <= state_d;
            grant_q <= grant_d;
        end
    end

    assign grant = grant_q;
    assign busy  = (state_q == GATE_BUSY);
endmodule

// File: rtl/xfer_nmi_gate.sv
module xfer_nmi_gate
    import xfer_gate_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned NUM_SRC = 4,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'('h80)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] nmi_src,
    output logic               nmi_flag,
    input  logic               act_req,
    input  logic               xfer_done,
    output logic               act_grant,
    output logic               xfer_busy
);
    bus_op_t op;

    xfer_bus_decode #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_decode (
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .op        (op)
    );

    xfer_nmi_flag #(
        .NUM_SRC (NUM_SRC)
    ) u_flag (
        .clk  (clk),
        .rst  (rst),
        .src  (nmi_src),
        .op   (op),
        .flag (nmi_flag)
    );

    xfer_rd_port #(
        .DATA_W (DATA_W)
    ) u_rd (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .flag  (nmi_flag),
        .rdata (bus_rdata)
    );

    xfer_act_gate u_gate (
        .clk   (clk),
        .rst   (rst),
        .req   (act_req),
        .done  (xfer_done),
        .flag  (nmi_flag),
        .grant (act_grant),
        .busy  (xfer_busy)
    );
endmodule

// File: rtl/xfer_nmi_gate_chk.sv
module xfer_nmi_gate_chk #(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned NUM_SRC = 4,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'('h80)
) (
    input logic               clk,
    input logic               rst,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic               wdata0,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic [NUM_SRC-1:0] nmi_src,
    input logic               nmi_flag,
    input logic               act_req,
    input logic               xfer_done,
    input logic               act_grant,
    input logic               xfer_busy
);
    assert_src_sets_flag_R2: assert property (@(posedge clk) disable iff (rst)
        (|nmi_src) |=> nmi_flag);

    assert_fall_only_on_write_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(nmi_flag) |-> $past(bus_wr && (bus_addr == CTRL_ADDR) && !wdata0));

    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[DATA_W-1:1] == '0);

    assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (rst)
        ((|nmi_src) && bus_wr) |=> nmi_flag);

    assert_grant_gated_R10: assert property (@(posedge clk) disable iff (rst)
        act_grant |-> $past(act_req && !nmi_flag && !xfer_busy));

    assert_grant_with_busy_R11: assert property (@(posedge clk) disable iff (rst)
        act_grant |-> xfer_busy);

    assert_busy_until_done_R12: assert property (@(posedge clk) disable iff (rst)
        (xfer_busy && !xfer_done) |=> xfer_busy);

    assert_no_grant_when_busy_R13: assert property (@(posedge clk) disable iff (rst)
        $past(xfer_busy) |-> !act_grant);
endmodule

bind xfer_nmi_gate xfer_nmi_gate_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_SRC   (NUM_SRC),
    .CTRL_ADDR (CTRL_ADDR)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .wdata0    (bus_wdata[0]),
    .bus_rdata (bus_rdata),
    .nmi_src   (nmi_src),
    .nmi_flag  (nmi_flag),
    .act_req   (act_req),
    .xfer_done (xfer_done),
    .act_grant (act_grant),
    .xfer_busy (xfer_busy)
);

// File: tb/xfer_nmi_gate_tb.sv
module xfer_nmi_gate_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] CTRL = 8'h80;
    localparam logic [7:0] OTHER = 8'h81;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] nmi_src = '0;
    logic       nmi_flag;
    logic       act_req = 1'b0;
    logic       xfer_done = 1'b0;
    logic       act_grant;
    logic       xfer_busy;

    int n_checks = 0;
    int n_fails  = 0;

    // Reference model state
    logic       m_flag = 1'b0;
    logic       m_armed = 1'b0;
    logic       m_busy = 1'b0;
    logic       m_grant = 1'b0;
    logic [7:0] m_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xfer_nmi_gate dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .nmi_src   (nmi_src),
        .nmi_flag  (nmi_flag),
        .act_req   (act_req),
        .xfer_done (xfer_done),
        .act_grant (act_grant),
        .xfer_busy (xfer_busy)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rdata(input logic rd, input logic [7:0] addr,
                                             input logic flag, input logic [7:0] prev);
        if (!rd) return prev;
        return (addr == CTRL && flag) ? 8'h01 : 8'h00;
    endfunction

    function automatic logic exp_flag(input logic [3:0] src, input logic wr, input logic [7:0] addr,
                                      input logic [7:0] wd, input logic armed, input logic flag);
        if (|src) return 1'b1;
        if (wr && addr == CTRL && !wd[0] && armed) return 1'b0;
        return flag;
    endfunction

    // Called at a negedge: drive, advance one edge, compare at the next negedge
    task automatic step(input logic [7:0] addr, input logic wr, input logic rd,
                        input logic [7:0] wd, input logic [3:0] src,
                        input logic req, input logic done, input string tag);
        logic n_flag, n_armed, n_grant, n_busy;
        logic [7:0] n_rdata;
        bus_addr = addr; bus_wr = wr; bus_rd = rd; bus_wdata = wd;
        nmi_src = src; act_req = req; xfer_done = done;
        n_rdata = exp_rdata(rd, addr, m_flag, m_rdata);
        n_flag  = exp_flag(src, wr, addr, wd, m_armed, m_flag);
        n_armed = (wr && addr == CTRL) ? 1'b0 : (rd && addr == CTRL) ? m_flag : m_armed;
        n_grant = req && !m_flag && !m_busy;
        n_busy  = n_grant ? 1'b1 : (m_busy && done) ? 1'b0 : m_busy;
        m_flag = n_flag; m_armed = n_armed; m_grant = n_grant; m_busy = n_busy; m_rdata = n_rdata;
        @(posedge clk);
        @(negedge clk);
        chk(tag, "nmi_flag", nmi_flag, m_flag);
        chk(tag, "bus_rdata", bus_rdata, m_rdata);
        chk(tag, "act_grant", act_grant, m_grant);
        chk(tag, "xfer_busy", xfer_busy, m_busy);
    endtask

    task automatic idle(input string tag);
        step(CTRL, 1'b0, 1'b0, 8'h00, 4'h0, 1'b0, 1'b0, tag);
    endtask
    task automatic rd_reg(input logic [7:0] a, input string tag);
        step(a, 1'b0, 1'b1, 8'h00, 4'h0, 1'b0, 1'b0, tag);
    endtask
    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d, input string tag);
        step(a, 1'b1, 1'b0, d, 4'h0, 1'b0, 1'b0, tag);
    endtask
    task automatic pulse(input logic [3:0] s, input string tag);
        step(CTRL, 1'b0, 1'b0, 8'h00, s, 1'b0, 1'b0, tag);
    endtask
    task automatic request(input logic done, input string tag);
        step(CTRL, 1'b0, 1'b0, 8'h00, 4'h0, 1'b1, done, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1", "nmi_flag", nmi_flag, 0);
        chk("R1", "bus_rdata", bus_rdata, 0);
        chk("R1", "act_grant", act_grant, 0);
        chk("R1", "xfer_busy", xfer_busy, 0);

        // R3 / R5: read returns 0, write 0 leaves flag at 0
        rd_reg(CTRL, "R3");
        wr_reg(CTRL, 8'h00, "R5");

        // R2: each source alone sets the flag; clear in between
        for (int s = 0; s < 4; s++) begin
            pulse(4'(1 << s), "R2");
            rd_reg(CTRL, "R3");
            chk("R3", "read value", bus_rdata, 8'h01);
            wr_reg(CTRL, 8'hFE, "R4");
            chk("R4", "flag cleared", nmi_flag, 0);
        end

        // R6 / R8: write of 1 uses up the arming; next clear fails
        pulse(4'h1, "R2");
        rd_reg(CTRL, "R3");
        wr_reg(CTRL, 8'h01, "R6");
        wr_reg(CTRL, 8'h00, "R8");
        chk("R8", "flag kept after disarm", nmi_flag, 1);
        // R7: reserved bits written 1, read back 0
        rd_reg(CTRL, "R7");
        wr_reg(CTRL, 8'hFE, "R7");
        rd_reg(CTRL, "R7");
        chk("R7", "reserved readback", bus_rdata, 8'h00);

        // R5: read returns 0, then event, then write 0 -> flag stays
        pulse(4'h8, "R5");
        chk("R5", "flag set", nmi_flag, 1);
        wr_reg(CTRL, 8'h00, "R4");
        rd_reg(CTRL, "R5");
        wr_reg(CTRL, 8'h00, "R4");
        rd_reg(CTRL, "R5");
        chk("R5", "cleared baseline", bus_rdata, 0);
        pulse(4'h4, "R5");
        wr_reg(CTRL, 8'h00, "R5");
        chk("R5", "flag kept", nmi_flag, 1);

        // R9: event and valid clear in same cycle
        rd_reg(CTRL, "R9");
        step(CTRL, 1'b1, 1'b0, 8'h00, 4'h2, 1'b0, 1'b0, "R9");
        chk("R9", "set wins", nmi_flag, 1);

        // R6: other-address write keeps flag and arming; other-address read returns 0
        rd_reg(CTRL, "R6");
        wr_reg(OTHER, 8'h00, "R6");
        chk("R6", "flag after other write", nmi_flag, 1);
        rd_reg(OTHER, "R3");
        chk("R3", "other read", bus_rdata, 0);
        wr_reg(CTRL, 8'h00, "R6");
        chk("R6", "arming survived", nmi_flag, 0);

        // R10: request while flag set is dropped, not queued
        pulse(4'h1, "R10");
        request(1'b0, "R10");
        chk("R10", "no grant", act_grant, 0);
        rd_reg(CTRL, "R10");
        wr_reg(CTRL, 8'h00, "R10");
        idle("R10");
        chk("R10", "not queued", xfer_busy, 0);

        // R11 / R13 / R12
        request(1'b0, "R11");
        chk("R11", "grant pulse", act_grant, 1);
        request(1'b0, "R13");
        chk("R13", "no grant while busy", act_grant, 0);
        pulse(4'h1, "R12");
        idle("R12");
        chk("R12", "busy held", xfer_busy, 1);
        step(CTRL, 1'b0, 1'b0, 8'h00, 4'h0, 1'b0, 1'b1, "R12");
        chk("R12", "busy dropped", xfer_busy, 0);
        rd_reg(CTRL, "R11");
        wr_reg(CTRL, 8'h00, "R11");

        // Constrained random mix
        void'($urandom(32'd20240611));
        for (int i = 0; i < 800; i++) begin
            logic [7:0] a;
            logic [3:0] s;
            a = ($urandom % 4 == 0) ? OTHER : CTRL;
            s = ($urandom % 10 == 0) ? 4'(1 << ($urandom % 4)) : 4'h0;
            step(a, ($urandom % 4 == 0), ($urandom % 3 == 0), 8'($urandom), s,
                 ($urandom % 3 == 0), ($urandom % 4 == 0), "random R2 R4 R11");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule